// File: doc/BRIEF.md
# Time Base and Interval Timer

This block keeps a 64-bit free-running time base and a 32-bit interval down-counter. Both move on one shared tick. The tick comes either from every core clock cycle or from the rising edges of a separate, asynchronous timer clock. The external clock is first brought into the core clock domain.

Software loads an interval through a small word-addressed register port. That write starts the countdown at once and also keeps the value for later reloads. When the counter steps down from one, it stops at zero and sets a sticky expiry flag. If automatic reload is switched on, the counter instead restarts from the saved value. The interrupt output is a level signal: the expiry flag gated by an enable bit. Software clears the flag by writing a one to it. Software can also read the time base and overwrite either of its 32-bit halves.

Top module: `interval_timebase`

## Requirements
- R1: The time base (low word read at address 0, high word at address 1) resets to 0, rises by exactly one on every tick, and wraps from all ones to zero.
- R2: Control register at address 3 holds three bits: bit 0 enables automatic reload, bit 1 enables the interrupt, and bit 2 selects the tick source. When bit 2 is 0, every core clock cycle is a tick. When bit 2 is 1, each rising edge of `ext_tclk` produces exactly one tick, and its effect becomes visible two clock edges after the first edge that samples the input high.
- R3: The interval counter (read at address 2) falls by one on each tick while its value is above one.
- R4: A tick that finds the counter at one makes it zero (without automatic reload) and sets the expiry flag, which reads as bit 0 of address 4.
- R5: With automatic reload enabled, a tick that finds the counter at one loads the value last written to address 2, sets the expiry flag, and counting goes on from there; a saved value of one expires on every tick.
- R6: `irq` is high exactly while the expiry flag and control bit 1 are both set.
- R7: Writing address 4 with bit 0 set clears the expiry flag. A write with bit 0 clear leaves the flag alone. An expiry in the same cycle as a clear leaves the flag set.
- R8: A write to address 2 loads the counter and the saved reload value on that clock edge, overriding any tick in the same cycle.
- R9: A counter at zero stays at zero and raises no further expiry until software writes a new interval, whatever the reload setting.
- R10: A write to address 0 or address 1 replaces that half of the time base on that clock edge. The other half keeps its value, and the time base does not advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_tclk | input | 1 | Asynchronous external timer clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
Every write, and every tick in core-clock mode, takes effect on the clock edge that samples it. Reads are combinational, so a result is visible in the same cycle it becomes due. An external clock edge adds two more edges of synchronizer and edge-detector delay before the counters move. The bench keeps a behavioural model that advances on the same edge as the design and models that delay with a three-deep history of sampled input levels. It compares the read data of the currently addressed register and the interrupt level half a cycle after each edge. That way every result is checked in the cycle it first becomes due, including expiry colliding with a status clear and writes colliding with ticks.

// File: rtl/itb_pkg.sv
`timescale 1ns/1ps
package itb_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_TB_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_TB_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] RA_STATUS = 3'd4;

  localparam int CTRL_W = 3;

  typedef struct packed {
    logic ext_src;   // bit 2
    logic irq_en;    // bit 1
    logic auto_rl;   // bit 0
  } ctrl_t;
endpackage

// File: rtl/itb_tick_gen.sv
`timescale 1ns/1ps
module itb_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_in,
  input  logic use_ext,
  output logic ext_edge,
  output logic tick
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], ext_clk_in};
  end

  // newest synchronized level high, previous level low
  assign ext_edge = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign tick     = use_ext ? ext_edge : 1'b1;
endmodule

// File: rtl/itb_time_base.sv
`timescale 1ns/1ps
module itb_time_base #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] tb
);
  localparam int TB_W = 2 * HALF_W;

  function automatic logic [TB_W-1:0] tb_next(
    input logic [TB_W-1:0]   cur,
    input logic              adv,
    input logic              lo,
    input logic              hi,
    input logic [HALF_W-1:0] d
  );
    logic [TB_W-1:0] r;
    r = cur;
    if (lo)       r[HALF_W-1:0]    = d;
    else if (hi)  r[TB_W-1:HALF_W] = d;
    else if (adv) r = cur + TB_W'(1);
    return r;
  endfunction

  logic [TB_W-1:0] tb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_next(tb_q, tick, wr_lo, wr_hi, wdata);
  end

  assign tb = tb_q;
endmodule

// File: rtl/itb_interval.sv
`timescale 1ns/1ps
module itb_interval #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             auto_reload,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // returns {expire, next count}
  function automatic logic [CNT_W:0] cnt_step(
    input logic [CNT_W-1:0] cur,
    input logic             adv,
    input logic             auto_en,
    input logic [CNT_W-1:0] rel
  );
    logic [CNT_W:0] r;
    r = {1'b0, cur};
    if (adv && cur == ONE)     r = {1'b1, (auto_en ? rel : '0)};
    else if (adv && cur > ONE) r = {1'b0, cur - ONE};
    return r;
  endfunction

  logic [CNT_W-1:0] count_q, reload_q, step_val;
  logic             step_exp;

  always_comb begin
    {step_exp, step_val} = cnt_step(count_q, tick, auto_reload, reload_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
    end else if (load) begin
      count_q  <= load_val;
      reload_q <= load_val;
    end else begin
      count_q  <= step_val;
    end
  end

  assign count  = count_q;
  assign reload = reload_q;
  assign expire = step_exp & ~load;
endmodule

// File: rtl/interval_timebase.sv
`timescale 1ns/1ps
module interval_timebase
  import itb_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tclk,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int TB_W  = 2 * DATA_W;
  localparam int CNT_W = DATA_W;

  // named internal events
  logic             tick, ext_edge;
  logic             wr_tb_lo, wr_tb_hi, tb_wr, wr_count, wr_ctrl, clr_req;
  logic             expire;
  logic [TB_W-1:0]  tb;
  logic [CNT_W-1:0] count, reload;
  ctrl_t            ctrl_q;
  logic             status_q;

  assign wr_tb_lo = reg_wr && reg_addr == RA_TB_LO;
  assign wr_tb_hi = reg_wr && reg_addr == RA_TB_HI;
  assign tb_wr    = wr_tb_lo | wr_tb_hi;
  assign wr_count = reg_wr && reg_addr == RA_COUNT;
  assign wr_ctrl  = reg_wr && reg_addr == RA_CTRL;
  assign clr_req  = reg_wr && reg_addr == RA_STATUS && reg_wdata[0];

  itb_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_clk_in (ext_tclk),
    .use_ext    (ctrl_q.ext_src),
    .ext_edge   (ext_edge),
    .tick       (tick)
  );

  itb_time_base #(.HALF_W(DATA_W)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wr_lo (wr_tb_lo),
    .wr_hi (wr_tb_hi),
    .wdata (reg_wdata),
    .tb    (tb)
  );

  itb_interval #(.CNT_W(CNT_W)) u_int (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .load        (wr_count),
    .load_val    (reg_wdata),
    .auto_reload (ctrl_q.auto_rl),
    .count       (count),
    .reload      (reload),
    .expire      (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (expire)       status_q <= 1'b1;
      else if (clr_req) status_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_TB_LO:  reg_rdata = tb[DATA_W-1:0];
      RA_TB_HI:  reg_rdata = tb[TB_W-1:DATA_W];
      RA_COUNT:  reg_rdata = count;
      RA_CTRL:   reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      RA_STATUS: reg_rdata = {{(DATA_W-1){1'b0}}, status_q};
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = status_q & ctrl_q.irq_en;
endmodule

// File: rtl/itb_checker.sv
`timescale 1ns/1ps
module itb_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              use_ext,
  input logic              tb_wr,
  input logic [2*DATA_W-1:0] tb,
  input logic              load,
  input logic [DATA_W-1:0] load_val,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] reload,
  input logic              auto_rl,
  input logic              expire,
  input logic              clr_req,
  input logic              status
);
  localparam int TB_W = 2 * DATA_W;

  assert_tb_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !tb_wr |=> tb == $past(tb) + TB_W'(1));

  assert_ext_single_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    use_ext && tick |=> !tick || !use_ext);

  assert_count_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && count > DATA_W'(1) |=> count == $past(count) - DATA_W'(1));

  assert_expire_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status);

  assert_stop_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !auto_rl |=> count == '0);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire && auto_rl |=> count == $past(reload));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !expire |=> !status);

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val) && reload == $past(load_val));

  assert_zero_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 && !load |=> count == '0);
endmodule

bind interval_timebase itb_checker #(.DATA_W(DATA_W)) u_itb_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .use_ext  (ctrl_q.ext_src),
  .tb_wr    (tb_wr),
  .tb       (tb),
  .load     (wr_count),
  .load_val (reg_wdata),
  .count    (count),
  .reload   (reload),
  .auto_rl  (ctrl_q.auto_rl),
  .expire   (expire),
  .clr_req  (clr_req),
  .status   (status_q)
);

// File: tb/interval_timebase_test.sv
`timescale 1ns/1ps
module interval_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_in = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  always #5 clk = ~clk;

  interval_timebase uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_tclk  (ext_in),
    .reg_wr    (wr),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .irq       (irq)
  );

  int    tests = 0;
  int    fails = 0;
  bit    done  = 1'b0;
  string scen  = "reset";

  // behavioural reference
  logic [63:0] m_tb;
  logic [31:0] m_cnt, m_rel;
  logic [2:0]  m_ctrl;
  logic        m_st;
  logic        h1, h2, h3;

  always @(posedge clk) begin : model
    logic        tk, ex;
    logic [63:0] ntb;
    logic [31:0] ncnt, nrel;
    if (!rst_n) begin
      m_tb = 0; m_cnt = 0; m_rel = 0; m_ctrl = 0; m_st = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      tk = m_ctrl[2] ? (h2 && !h3) : 1'b1;
      ex = 1'b0;
      ntb = m_tb; ncnt = m_cnt; nrel = m_rel;
      if (wr && addr == 3'd0)      ntb[31:0]  = wdata;
      else if (wr && addr == 3'd1) ntb[63:32] = wdata;
      else if (tk)                 ntb = m_tb + 64'd1;
      if (wr && addr == 3'd2) begin
        ncnt = wdata; nrel = wdata;
      end else if (tk && m_cnt == 32'd1) begin
        ex = 1'b1;
        ncnt = m_ctrl[0] ? m_rel : 32'd0;
      end else if (tk && m_cnt > 32'd1) begin
        ncnt = m_cnt - 32'd1;
      end
      if (ex) m_st = 1'b1;
      else if (wr && addr == 3'd4 && wdata[0]) m_st = 1'b0;
      if (wr && addr == 3'd3) m_ctrl = wdata[2:0];
      m_tb = ntb; m_cnt = ncnt; m_rel = nrel;
      h3 = h2; h2 = h1; h1 = ext_in;
    end
  end

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_tb[31:0];
      3'd1: return m_tb[63:32];
      3'd2: return m_cnt;
      3'd3: return {29'd0, m_ctrl};
      3'd4: return {31'd0, m_st};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string addr_req(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R1";
      3'd2:       return "R3";
      3'd3:       return "R2";
      3'd4:       return "R7";
      default:    return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, scen, act, exp);
    end
  endtask

  // one cycle: compare results due now, then drive next inputs
  task automatic cycle(input logic w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    check(addr_req(addr), rdata, mread(addr));
    check("R6", irq, m_st && m_ctrl[1]);
    wr = w; addr = a; wdata = d;
  endtask

  task automatic idle(input logic [2:0] a, input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, a, 32'd0);
  endtask

  task automatic ext_pulses(input int hi, input int lo, input int reps, input logic [2:0] a);
    for (int r = 0; r < reps; r++) begin
      ext_in = 1'b1;
      idle(a, hi);
      ext_in = 1'b0;
      idle(a, lo);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog [%s] actual=running expected=finished", scen);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // reset state, read while held in reset
    for (int a = 0; a < 5; a++) begin
      addr = 3'(a);
      #1;
      check(a < 2 ? "R1" : (a == 2 ? "R3" : (a == 3 ? "R2" : "R7")), rdata, 0);
    end
    check("R6", irq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    addr = 3'd0;

    scen = "R1 free run";
    idle(3'd0, 6);
    idle(3'd1, 2);

    scen = "R3 R4 R6 count down and expire";
    cycle(1'b1, 3'd3, 32'h2);
    cycle(1'b1, 3'd2, 32'd4);
    idle(3'd2, 6);
    idle(3'd4, 2);

    scen = "R7 write zero keeps flag";
    cycle(1'b1, 3'd4, 32'h0);
    idle(3'd4, 2);
    scen = "R7 clear";
    cycle(1'b1, 3'd4, 32'h1);
    idle(3'd4, 2);

    scen = "R9 zero holds";
    idle(3'd2, 4);
    idle(3'd4, 2);
    cycle(1'b1, 3'd3, 32'h3);
    idle(3'd2, 3);
    idle(3'd4, 1);

    scen = "R5 auto reload";
    cycle(1'b1, 3'd2, 32'd3);
    idle(3'd2, 8);
    idle(3'd4, 1);
    scen = "R5 reload of one";
    cycle(1'b1, 3'd2, 32'd1);
    cycle(1'b1, 3'd4, 32'h1);
    idle(3'd4, 3);
    idle(3'd2, 2);

    scen = "R7 expiry beats clear";
    cycle(1'b1, 3'd3, 32'h2);
    cycle(1'b1, 3'd2, 32'd2);
    cycle(1'b0, 3'd4, 32'd0);
    cycle(1'b1, 3'd4, 32'h1);
    idle(3'd4, 2);
    cycle(1'b1, 3'd4, 32'h1);
    idle(3'd4, 2);

    scen = "R8 load overrides tick";
    cycle(1'b1, 3'd2, 32'd10);
    idle(3'd2, 3);
    cycle(1'b1, 3'd2, 32'd7);
    idle(3'd2, 3);
    cycle(1'b1, 3'd2, 32'h8000_0000);
    idle(3'd2, 2);

    scen = "R10 half writes and R1 wrap";
    cycle(1'b1, 3'd0, 32'hFFFF_FFFD);
    idle(3'd1, 1);
    cycle(1'b1, 3'd1, 32'hFFFF_FFFF);
    idle(3'd0, 1);
    idle(3'd1, 1);
    idle(3'd0, 3);
    idle(3'd1, 2);
    cycle(1'b1, 3'd1, 32'h0000_0012);
    idle(3'd1, 1);
    idle(3'd0, 2);

    scen = "R2 external tick source";
    cycle(1'b1, 3'd2, 32'd3);
    cycle(1'b1, 3'd3, 32'h6);
    cycle(1'b1, 3'd4, 32'h1);
    idle(3'd0, 4);
    ext_pulses(1, 1, 3, 3'd0);
    ext_pulses(3, 5, 3, 3'd2);
    ext_pulses(6, 2, 2, 3'd0);
    idle(3'd4, 4);
    scen = "R2 R8 load during external mode";
    cycle(1'b1, 3'd2, 32'd2);
    ext_pulses(2, 3, 3, 3'd2);
    idle(3'd4, 2);
    scen = "R2 back to core clock";
    cycle(1'b1, 3'd3, 32'h0);
    ext_in = 1'b1;
    idle(3'd0, 4);
    ext_in = 1'b0;
    idle(3'd0, 2);
    cycle(1'b1, 3'd3, 32'h4);
    idle(3'd0, 6);
    idle(3'd7, 1);
    idle(3'd0, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule